// File: doc/BRIEF.md
# CAN Transceiver Standby and Bus Wakeup Controller

This block is the digital control core of a CAN bus transceiver. A standby select input chooses between two modes. In normal mode the transmitter, the normal receiver and the split-reference source are enabled, and the receive data output follows the sampled bus state. In standby mode all three are off. A low-power comparator bit is then watched and filtered into a wakeup indication on the same receive data output. The analog parts are outside the block: comparators arrive as sampled digital bits, and drivers and the split source leave as enables.

The wakeup indication is not latched. It drops as soon as the bus has been recessive for a set release time. A static strap selects one of two variants. In the first, a dominant level already on the bus when standby begins counts toward a wakeup. In the second, a wakeup is armed only after the bus has been seen recessive at least once in standby, so a bus stuck dominant cannot keep the node awake. Every filter and delay is a clock-cycle count, derived from a time in nanoseconds divided by the clock period and never less than one.

Top module: `can_wake_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the block is in standby: `normal_o`, `tx_en_o`, `rx_en_o` and `split_en_o` are 0 and `rxd_o` is 1.
- R2: When `stby_sel_i` is sampled 1, the block is in standby after that same clock edge, including while a switch to normal is still pending.
- R3: When `stby_sel_i` is sampled 0 in standby, `normal_o` rises on the (NORM_CYC+1)-th consecutive rising edge that samples it 0, where NORM_CYC = NORM_DLY_NS / CLK_PERIOD_NS.
- R4: A return of `stby_sel_i` to 1 during the pending delay cancels the switch. A later request waits the full delay again.
- R5: In normal mode, `rxd_o` is the inverse of `norm_rx_dom_i` (1 = dominant gives `rxd_o` = 0). In standby, `norm_rx_dom_i` has no effect on `rxd_o`.
- R6: In standby, once armed, `rxd_o` goes to 0 on the edge that samples the FILT_CYC-th consecutive `lp_rx_dom_i` = 1 (FILT_CYC = WAKE_FILT_NS / CLK_PERIOD_NS). FILT_CYC-1 consecutive dominant samples do not wake.
- R7: A single recessive sample in standby restarts the wake filter count from zero.
- R8: After a wakeup, `rxd_o` returns to 1 on the edge that samples the REL_CYC-th consecutive recessive `lp_rx_dom_i` = 0 (REL_CYC = WAKE_REL_NS / CLK_PERIOD_NS). A dominant sample restarts this count.
- R9: With `wake_variant_i` = 0, a dominant already present when standby begins is counted from the first standby sample.
- R10: With `wake_variant_i` = 1, the wake filter stays idle until `lp_rx_dom_i` = 0 has been sampled in standby. A bus dominant from standby entry onward never wakes.
- R11: `tx_en_o`, `rx_en_o` and `split_en_o` are 1 only while `normal_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_sel_i | input | 1 | 1 requests standby, 0 requests normal mode |
| norm_rx_dom_i | input | 1 | Sampled normal receiver, 1 = bus dominant |
| lp_rx_dom_i | input | 1 | Sampled low-power receiver, 1 = bus dominant |
| wake_variant_i | input | 1 | Static strap: 0 = entry dominant counts, 1 = arm after first recessive |
| rxd_o | output | 1 | Receive data to the protocol controller, low = dominant or wakeup |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Normal receiver enable |
| split_en_o | output | 1 | Split-reference source enable |
| normal_o | output | 1 | Mode status, 1 = normal mode active |

## Verification
Some properties are checked on every cycle. Standby follows a sampled standby request on the next edge. Normal mode is never entered unless the request was low. The enables are quiet outside normal mode, and `rxd_o` tracks the normal receiver in normal mode. In standby, every fall of `rxd_o` is preceded by a dominant sample and every rise by a recessive one.

The exact cycle counts need the bench's directed scenarios. These cover the normal-entry delay and its cancellation, the wake filter at FILT_CYC-1 and FILT_CYC samples, the filter restarting after a recessive sample, the release count and its restart, and the two strap variants against a dominant present at standby entry.

// File: rtl/can_wake_pkg.sv
package can_wake_pkg;

  typedef enum logic [1:0] {
    MODE_STBY = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_NORM = 2'd2
  } mode_e;

  // time in ns to whole clock cycles, never below one
  function automatic int ns_to_cyc(input int t_ns, input int per_ns);
    return (t_ns / per_ns < 1) ? 1 : t_ns / per_ns;
  endfunction

  function automatic int cnt_w(input int lim);
    return (lim > 1) ? $clog2(lim) : 1;
  endfunction

endpackage

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_wake_pkg::*;
#(
  parameter int NORM_CYC = 1500
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  stby_sel_i,
  output mode_e mode_o
);

  localparam int NW = cnt_w(NORM_CYC);
  localparam logic [NW-1:0] NLIM = NW'(NORM_CYC - 1);

  mode_e mode_q;
  logic [NW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STBY;
      cnt_q  <= '0;
    end else begin
      unique case (mode_q)
        MODE_STBY: begin
          cnt_q <= '0;
          if (!stby_sel_i) mode_q <= MODE_WAIT;
        end
        MODE_WAIT: begin
          if (stby_sel_i) begin
            mode_q <= MODE_STBY;
            cnt_q  <= '0;
          end else if (cnt_q == NLIM) begin
            mode_q <= MODE_NORM;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        MODE_NORM: begin
          cnt_q <= '0;
          if (stby_sel_i) mode_q <= MODE_STBY;
        end
        default: begin
          mode_q <= MODE_STBY;
          cnt_q  <= '0;
        end
      endcase
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/can_wake_filter.sv
module can_wake_filter
  import can_wake_pkg::*;
#(
  parameter int FILT_CYC = 500,
  parameter int REL_CYC  = 580
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic lp_dom_i,
  input  logic var_b_i,
  output logic wake_o
);

  localparam int FW = cnt_w(FILT_CYC);
  localparam int RW = cnt_w(REL_CYC);
  localparam logic [FW-1:0] FLIM = FW'(FILT_CYC - 1);
  localparam logic [RW-1:0] RLIM = RW'(REL_CYC - 1);

  logic          armed_q;
  logic          wake_q;
  logic [FW-1:0] fcnt_q;
  logic [RW-1:0] rcnt_q;
  logic          arm;

  // variant A counts at once, variant B waits for a recessive sample
  assign arm = armed_q | ~var_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      wake_q  <= 1'b0;
      fcnt_q  <= '0;
      rcnt_q  <= '0;
    end else if (!active_i) begin
      armed_q <= 1'b0;
      wake_q  <= 1'b0;
      fcnt_q  <= '0;
      rcnt_q  <= '0;
    end else begin
      if (!lp_dom_i) armed_q <= 1'b1;

      if (!lp_dom_i || !arm) fcnt_q <= '0;
      else if (fcnt_q != FLIM) fcnt_q <= fcnt_q + 1'b1;

      if (!wake_q) begin
        rcnt_q <= '0;
        if (arm && lp_dom_i && fcnt_q == FLIM) wake_q <= 1'b1;
      end else if (lp_dom_i) begin
        rcnt_q <= '0;
      end else if (rcnt_q == RLIM) begin
        wake_q <= 1'b0;
        rcnt_q <= '0;
      end else begin
        rcnt_q <= rcnt_q + 1'b1;
      end
    end
  end

  assign wake_o = wake_q;

endmodule

// File: rtl/can_wake_ctrl.sv
module can_wake_ctrl
  import can_wake_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int WAKE_FILT_NS  = 2500,
  parameter int WAKE_REL_NS   = 2900,
  parameter int NORM_DLY_NS   = 7500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_sel_i,
  input  logic norm_rx_dom_i,
  input  logic lp_rx_dom_i,
  input  logic wake_variant_i,
  output logic rxd_o,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic split_en_o,
  output logic normal_o
);

  localparam int FILT_CYC = ns_to_cyc(WAKE_FILT_NS, CLK_PERIOD_NS);
  localparam int REL_CYC  = ns_to_cyc(WAKE_REL_NS, CLK_PERIOD_NS);
  localparam int NORM_CYC = ns_to_cyc(NORM_DLY_NS, CLK_PERIOD_NS);

  mode_e mode;
  logic  in_norm;
  logic  wake;

  can_mode_fsm #(.NORM_CYC(NORM_CYC)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stby_sel_i (stby_sel_i),
    .mode_o     (mode)
  );

  assign in_norm = (mode == MODE_NORM);

  can_wake_filter #(.FILT_CYC(FILT_CYC), .REL_CYC(REL_CYC)) u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (~in_norm),
    .lp_dom_i (lp_rx_dom_i),
    .var_b_i  (wake_variant_i),
    .wake_o   (wake)
  );

  assign rxd_o      = in_norm ? ~norm_rx_dom_i : ~wake;
  assign tx_en_o    = in_norm;
  assign rx_en_o    = in_norm;
  assign split_en_o = in_norm;
  assign normal_o   = in_norm;

endmodule

// File: rtl/can_wake_ctrl_chk.sv
module can_wake_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic stby_sel_i,
  input logic norm_rx_dom_i,
  input logic lp_rx_dom_i,
  input logic wake_variant_i,
  input logic rxd_o,
  input logic tx_en_o,
  input logic rx_en_o,
  input logic split_en_o,
  input logic normal_o
);

  AST_STBY_NEXT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_sel_i |=> !normal_o); // R2

  AST_NORM_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(normal_o) |-> $past(!stby_sel_i)); // R3

  AST_RXD_FOLLOWS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (normal_o && norm_rx_dom_i) |-> !rxd_o); // R5

  AST_WAKE_AFTER_DOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!normal_o && $past(!normal_o) && $fell(rxd_o)) |-> $past(lp_rx_dom_i)); // R6

  AST_RELEASE_AFTER_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!normal_o && $past(!normal_o) && $rose(rxd_o)) |-> $past(!lp_rx_dom_i)); // R8

  AST_STBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !normal_o |-> (!tx_en_o && !rx_en_o && !split_en_o)); // R11

endmodule

bind can_wake_ctrl can_wake_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stby_sel_i     (stby_sel_i),
  .norm_rx_dom_i  (norm_rx_dom_i),
  .lp_rx_dom_i    (lp_rx_dom_i),
  .wake_variant_i (wake_variant_i),
  .rxd_o          (rxd_o),
  .tx_en_o        (tx_en_o),
  .rx_en_o        (rx_en_o),
  .split_en_o     (split_en_o),
  .normal_o       (normal_o)
);

// File: tb/can_wake_ctrl_test.sv
`timescale 1ns/1ps
module can_wake_ctrl_test;

  localparam int PER  = 5;
  localparam int FILT = 20;  // 100 ns
  localparam int REL  = 12;  // 60 ns
  localparam int NORM = 30;  // 150 ns

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stby_sel_i = 1'b1;
  logic norm_rx_dom_i = 1'b0;
  logic lp_rx_dom_i = 1'b0;
  logic wake_variant_i = 1'b0;
  logic rxd_o, tx_en_o, rx_en_o, split_en_o, normal_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  can_wake_ctrl #(
    .CLK_PERIOD_NS(PER), .WAKE_FILT_NS(FILT*PER),
    .WAKE_REL_NS(REL*PER), .NORM_DLY_NS(NORM*PER)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .stby_sel_i(stby_sel_i),
    .norm_rx_dom_i(norm_rx_dom_i), .lp_rx_dom_i(lp_rx_dom_i),
    .wake_variant_i(wake_variant_i), .rxd_o(rxd_o), .tx_en_o(tx_en_o),
    .rx_en_o(rx_en_o), .split_en_o(split_en_o), .normal_o(normal_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic go_normal();
    stby_sel_i = 1'b0;
    tick(NORM + 1);
  endtask

  task automatic t_reset();
    #1;
    check("R1 normal in reset", normal_o, 1'b0);
    check("R1 rxd in reset", rxd_o, 1'b1);
    rst_ni = 1'b1;
    tick(2);
    check("R1 tx_en after reset", tx_en_o, 1'b0);
    check("R1 split_en after reset", split_en_o, 1'b0);
    check("R1 rxd after reset", rxd_o, 1'b1);
  endtask

  task automatic t_norm_delay();
    stby_sel_i = 1'b0;
    tick(NORM);
    check("R3 normal before delay", normal_o, 1'b0);
    check("R11 tx_en while pending", tx_en_o, 1'b0);
    tick(1);
    check("R3 normal at delay", normal_o, 1'b1);
    check("R11 tx_en in normal", tx_en_o, 1'b1);
    check("R11 rx_en in normal", rx_en_o, 1'b1);
    check("R11 split_en in normal", split_en_o, 1'b1);
  endtask

  task automatic t_normal_rxd();
    norm_rx_dom_i = 1'b1; #1;
    check("R5 rxd dominant in normal", rxd_o, 1'b0);
    norm_rx_dom_i = 1'b0; #1;
    check("R5 rxd recessive in normal", rxd_o, 1'b1);
    lp_rx_dom_i = 1'b1;
    tick(FILT + 2);
    check("R5 lp receiver ignored in normal", rxd_o, 1'b1);
    lp_rx_dom_i = 1'b0;
    tick(1);
  endtask

  task automatic t_stby_entry();
    stby_sel_i = 1'b1;
    tick(1);
    check("R2 standby after one edge", normal_o, 1'b0);
    check("R11 split_en off in standby", split_en_o, 1'b0);
    norm_rx_dom_i = 1'b1;
    tick(3);
    check("R5 normal receiver ignored in standby", rxd_o, 1'b1);
    norm_rx_dom_i = 1'b0;
  endtask

  task automatic t_cancel();
    stby_sel_i = 1'b0;
    tick(NORM - 5);
    stby_sel_i = 1'b1;
    tick(1);
    check("R4 cancel keeps standby", normal_o, 1'b0);
    stby_sel_i = 1'b0;
    tick(NORM);
    check("R4 full delay again", normal_o, 1'b0);
    tick(1);
    check("R4 normal after restarted delay", normal_o, 1'b1);
    stby_sel_i = 1'b1;
    tick(1);
  endtask

  task automatic t_filter();
    wake_variant_i = 1'b0;
    lp_rx_dom_i = 1'b1;
    tick(FILT - 1);
    check("R6 short dominant no wake", rxd_o, 1'b1);
    lp_rx_dom_i = 1'b0;
    tick(1);
    lp_rx_dom_i = 1'b1;
    tick(FILT - 1);
    check("R7 count restarted", rxd_o, 1'b1);
    tick(1);
    check("R6 wake at filter count", rxd_o, 1'b0);
    lp_rx_dom_i = 1'b0;
    tick(REL - 1);
    check("R8 still low before release", rxd_o, 1'b0);
    lp_rx_dom_i = 1'b1;
    tick(1);
    lp_rx_dom_i = 1'b0;
    tick(REL - 1);
    check("R8 release count restarted", rxd_o, 1'b0);
    tick(1);
    check("R8 rxd high after release", rxd_o, 1'b1);
  endtask

  task automatic t_variant_a();
    wake_variant_i = 1'b0;
    go_normal();
    lp_rx_dom_i = 1'b1;
    stby_sel_i = 1'b1;
    tick(1);
    tick(FILT - 1);
    check("R9 no wake before filter", rxd_o, 1'b1);
    tick(1);
    check("R9 entry dominant wakes", rxd_o, 1'b0);
    lp_rx_dom_i = 1'b0;
    tick(REL);
    check("R8 release after variant A wake", rxd_o, 1'b1);
  endtask

  task automatic t_variant_b();
    wake_variant_i = 1'b1;
    go_normal();
    lp_rx_dom_i = 1'b1;
    stby_sel_i = 1'b1;
    tick(1);
    tick(3 * FILT);
    check("R10 stuck dominant ignored", rxd_o, 1'b1);
    lp_rx_dom_i = 1'b0;
    tick(1);
    lp_rx_dom_i = 1'b1;
    tick(FILT - 1);
    check("R10 armed, below filter", rxd_o, 1'b1);
    tick(1);
    check("R10 wake after release", rxd_o, 1'b0);
    lp_rx_dom_i = 1'b0;
    tick(REL);
    check("R8 release after variant B wake", rxd_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_norm_delay();
    t_normal_rxd();
    t_stby_entry();
    t_cancel();
    t_filter();
    t_variant_a();
    t_variant_b();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule